// File: doc/BRIEF.md
# Baud Tick Generator with Majority Line Sampler

This block sets the timing for a serial port. A fixed base prescaler feeds an 8-bit down-counter. The counter runs freely and reloads from a divisor value that software writes. From the counter's wrap the block makes three outputs: a one-clock bit tick at the selected bit rate, a 16-per-bit oversample strobe in the asynchronous modes, and a voted receive level taken from three samples near the middle of each bit.

Software writes a divisor, a synchronous-mode flag and a fast-rate flag through one write strobe. Every write restarts the prescaler, the counter and the oversample phase, so a new rate begins at once. Asynchronous slow mode divides the clock by 64 per divisor count. Asynchronous fast mode divides it by 16. Synchronous mode divides it by 4, and the fast flag has no effect there. An enable input freezes all timing while it is low.

The sampler is a state machine with four states. IDLE waits for the oversample strobe at phase 7 and takes the first sample (transition IDLE to GOT1). GOT1 takes the second sample on the next strobe (GOT1 to GOT2). GOT2 takes the third sample on the next strobe and registers the 2-of-3 vote (GOT2 to DECIDE). DECIDE lasts one clock, raises the valid flag and always returns to IDLE. Reset or any configuration write sends the machine to IDLE from any state.

Top module: `baud_tick_gen`

## Requirements
- R1: After synchronous reset, bit_tick, samp_tick and vote_valid are 0 and rx_vote is 1. The divisor is 0 and the mode is asynchronous slow, so with en high the first bit_tick comes 64 clocks after reset.
- R2: In asynchronous slow mode (cfg_sync=0, cfg_fast=0) the bit_tick period is 64·(X+1) clocks, where X is the 8-bit divisor.
- R3: In asynchronous fast mode (cfg_sync=0, cfg_fast=1) the bit_tick period is 16·(X+1) clocks.
- R4: In synchronous mode (cfg_sync=1) the bit_tick period is 4·(X+1) clocks, whatever the value of cfg_fast.
- R5: bit_tick is a single-clock pulse. The first tick after a restart comes exactly one full period after the restart edge, and no tick appears at any other time.
- R6: A divisor write restarts the timing at once. The next tick comes one new period after the write, and no tick arrives at the old period's end.
- R7: A write that changes only the mode bits also restarts the timing and applies the new rate immediately.
- R8: While en is low the prescaler, counter and phase hold their values and no bit_tick is issued, so every later tick is delayed by the number of disabled clocks.
- R9: In the asynchronous modes samp_tick pulses 16 times per bit period, once every period/16 clocks, and the 16th pulse coincides with bit_tick. In synchronous mode samp_tick never pulses.
- R10: rx_vote is the 2-of-3 majority of rx_in sampled on the oversample strobes of phases 7, 8 and 9. Phase 0 is the first strobe after a bit boundary or a restart.
- R11: vote_valid is a single-clock pulse one clock after the third sample. It never appears in synchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Generator enable; timing is frozen while low |
| cfg_we | input | 1 | Configuration write strobe; restarts the timing |
| cfg_div | input | 8 | Divisor value X |
| cfg_sync | input | 1 | 1 selects synchronous mode |
| cfg_fast | input | 1 | 1 selects the fast asynchronous rate |
| rx_in | input | 1 | Raw receive line |
| bit_tick | output | 1 | One-clock pulse per bit period |
| samp_tick | output | 1 | Oversample strobe, 16 per bit in the asynchronous modes |
| rx_vote | output | 1 | Majority-voted receive level |
| vote_valid | output | 1 | One-clock pulse when rx_vote has just been updated |

## Verification
Assertions check four rules on every cycle. A tick needs the enable. No tick follows directly after a restart. bit_tick and vote_valid never last two cycles in a row. A vote only follows an oversample strobe and never appears in synchronous mode. The bench scenarios show the behaviour that depends on arithmetic and history: the exact period for each mode and divisor (including the extreme divisor), the shift a stall causes, the first tick after a mid-period rewrite, the strobe count per bit, and the voted value for each sample pattern.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    typedef enum logic [1:0] {
        RATE_ASYNC_SLOW = 2'd0,
        RATE_ASYNC_FAST = 2'd1,
        RATE_SYNC       = 2'd2
    } rate_e;

    typedef enum logic [1:0] {
        VOTE_IDLE   = 2'd0,
        VOTE_GOT1   = 2'd1,
        VOTE_GOT2   = 2'd2,
        VOTE_DECIDE = 2'd3
    } vote_state_e;

endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic en,
    input  logic bypass,
    output logic pre_tick
);
    localparam int PRE_W = $clog2(PRE_DIV);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
        end else if (en) begin
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
    end

    // Fast mode passes every enabled clock straight to the counter.
    assign pre_tick = en && (bypass || (pre_q == PRE_LAST));
endmodule

// File: rtl/baud_timer.sv
module baud_timer #(
    parameter int DIV_W    = 8,
    parameter int OS_RATE  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     restart,
    input  logic                     pre_tick,
    input  logic                     oversample,
    input  logic [DIV_W-1:0]         load_div,
    input  logic [DIV_W-1:0]         div_q,
    output logic                     samp_tick,
    output logic                     bit_tick,
    output logic [$clog2(OS_RATE)-1:0] phase
);
    localparam int PH_W = $clog2(OS_RATE);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OS_RATE - 1);

    logic [DIV_W-1:0] cnt_q;
    logic [PH_W-1:0]  ph_q;
    logic             wrap;

    assign wrap = pre_tick && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ph_q  <= '0;
        end else if (restart) begin
            cnt_q <= load_div;
            ph_q  <= '0;
        end else if (pre_tick) begin
            if (cnt_q == '0) begin
                cnt_q <= div_q;
                if (oversample) begin
                    ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign samp_tick = wrap && oversample;
    assign bit_tick  = wrap && (!oversample || (ph_q == PH_LAST));
    assign phase     = ph_q;

    // R5: a bit tick never lasts two cycles
    assert_single_tick_R5: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);
endmodule

// File: rtl/baud_vote.sv
module baud_vote
    import baud_tick_pkg::*;
#(
    parameter int OS_RATE  = 16,
    parameter int VOTE_MID = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       restart,
    input  logic                       samp_tick,
    input  logic [$clog2(OS_RATE)-1:0] phase,
    input  logic                       rx_in,
    output logic                       rx_vote,
    output logic                       vote_valid
);
    localparam int PH_W = $clog2(OS_RATE);
    localparam logic [PH_W-1:0] PH_FIRST = PH_W'(VOTE_MID - 1);

    vote_state_e st_q, st_nx;
    logic        smp0_q, smp1_q;
    logic        first_take;

    assign first_take = samp_tick && (phase == PH_FIRST);

    // State register
    always_ff @(posedge clk) begin
        if (rst || restart) st_q <= VOTE_IDLE;
        else                st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            VOTE_IDLE:   if (first_take) st_nx = VOTE_GOT1;
            VOTE_GOT1:   if (samp_tick)  st_nx = VOTE_GOT2;
            VOTE_GOT2:   if (samp_tick)  st_nx = VOTE_DECIDE;
            VOTE_DECIDE: st_nx = VOTE_IDLE;
            default:     st_nx = VOTE_IDLE;
        endcase
    end

    // Outputs: sample capture and registered vote
    always_ff @(posedge clk) begin
        if (rst) begin
            smp0_q  <= 1'b1;
            smp1_q  <= 1'b1;
            rx_vote <= 1'b1;
        end else if (!restart) begin
            if (st_q == VOTE_IDLE && first_take) smp0_q <= rx_in;
            if (st_q == VOTE_GOT1 && samp_tick)  smp1_q <= rx_in;
            if (st_q == VOTE_GOT2 && samp_tick)
                rx_vote <= (smp0_q & smp1_q) | (smp0_q & rx_in) | (smp1_q & rx_in);
        end
    end

    assign vote_valid = (st_q == VOTE_DECIDE);

    // R11: valid lasts one clock and follows the third strobe
    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        vote_valid |=> !vote_valid);
    assert_vote_after_sample_R11: assert property (@(posedge clk) disable iff (rst)
        vote_valid |-> $past(samp_tick));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int PRE_DIV  = 4,
    parameter int OS_RATE  = 16,
    parameter int VOTE_MID = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cfg_we,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_sync,
    input  logic             cfg_fast,
    input  logic             rx_in,
    output logic             bit_tick,
    output logic             samp_tick,
    output logic             rx_vote,
    output logic             vote_valid
);
    localparam int PH_W = $clog2(OS_RATE);

    logic [DIV_W-1:0] div_q;
    rate_e            rate_q;
    logic             restart;
    logic             pre_tick;
    logic             oversample;
    logic             bypass;
    logic [PH_W-1:0]  phase;

    assign restart = cfg_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            rate_q <= RATE_ASYNC_SLOW;
        end else if (cfg_we) begin
            div_q  <= cfg_div;
            rate_q <= cfg_sync ? RATE_SYNC :
                      (cfg_fast ? RATE_ASYNC_FAST : RATE_ASYNC_SLOW);
        end
    end

    assign oversample = (rate_q != RATE_SYNC);
    assign bypass     = (rate_q == RATE_ASYNC_FAST);

    baud_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .en       (en),
        .bypass   (bypass),
        .pre_tick (pre_tick)
    );

    baud_timer #(.DIV_W(DIV_W), .OS_RATE(OS_RATE)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .pre_tick   (pre_tick),
        .oversample (oversample),
        .load_div   (cfg_div),
        .div_q      (div_q),
        .samp_tick  (samp_tick),
        .bit_tick   (bit_tick),
        .phase      (phase)
    );

    baud_vote #(.OS_RATE(OS_RATE), .VOTE_MID(VOTE_MID)) u_vote (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .samp_tick  (samp_tick),
        .phase      (phase),
        .rx_in      (rx_in),
        .rx_vote    (rx_vote),
        .vote_valid (vote_valid)
    );

    // R8: no tick without enable
    assert_tick_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> en);
    // R6: a restart is never followed directly by a tick
    assert_restart_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> !bit_tick);
    // R11: the sampler stays quiet in synchronous mode
    assert_sync_no_vote_R11: assert property (@(posedge clk) disable iff (rst)
        (rate_q == RATE_SYNC) |-> !vote_valid);
endmodule

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;
    logic       clk = 1'b0;
    logic       rst, en, cfg_we, cfg_sync, cfg_fast, rx_in;
    logic [7:0] cfg_div;
    logic       bit_tick, samp_tick, rx_vote, vote_valid;

    int checks = 0;
    int errors = 0;
    int n = 0;
    bit watch_vote = 1'b0;
    int tick_q[$];
    int vote_t[$];
    bit vote_v[$];

    always #2.5 clk = ~clk;

    baud_tick_gen uut (
        .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_div(cfg_div),
        .cfg_sync(cfg_sync), .cfg_fast(cfg_fast), .rx_in(rx_in),
        .bit_tick(bit_tick), .samp_tick(samp_tick), .rx_vote(rx_vote),
        .vote_valid(vote_valid)
    );

    // Cycle index since the last restart edge: 1 at the first negedge after it.
    always @(posedge clk) begin
        if (rst || cfg_we) n <= 1;
        else               n <= n + 1;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected items as the design produces them.
    always @(negedge clk) begin
        if (!rst) begin
            if (bit_tick) begin
                if (tick_q.size() == 0) check("R5 unexpected bit_tick at cycle", n, -1);
                else check("R5 bit_tick cycle", n, tick_q.pop_front());
            end
            if (watch_vote && vote_valid) begin
                if (vote_t.size() == 0) check("R11 unexpected vote_valid at cycle", n, -1);
                else begin
                    check("R11 vote_valid cycle", n, vote_t.pop_front());
                    check("R10 voted level", int'(rx_vote), int'(vote_v.pop_front()));
                end
            end
        end
    end

    task automatic wr(int d, bit s, bit f);
        @(negedge clk);
        cfg_div = 8'(d); cfg_sync = s; cfg_fast = f; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_n(int t);
        while (n < t) @(negedge clk);
    endtask

    task automatic expect_ticks(string req, int period, int count);
        for (int k = 1; k <= count; k++) tick_q.push_back(period * k);
        wait_n(period * count + 1);
        check(req, tick_q.size(), 0);
        tick_q.delete();
    endtask

    task automatic vote_case(bit a, bit b, bit c);
        wr(0, 1'b0, 1'b1);            // fast async, X=0: strobe every clock
        tick_q.push_back(16);
        vote_t.push_back(11);
        vote_v.push_back((a & b) | (a & c) | (b & c));
        while (n <= 17) begin
            rx_in = (n == 8) ? a : (n == 9) ? b : (n == 10) ? c : 1'b1;
            @(negedge clk);
        end
        rx_in = 1'b1;
        check("R11 all votes seen", vote_t.size(), 0);
        check("R5 vote bit tick seen", tick_q.size(), 0);
        vote_t.delete(); vote_v.delete(); tick_q.delete();
    endtask

    initial begin
        rst = 1'b1; en = 1'b1; cfg_we = 1'b0; cfg_div = 8'd0;
        cfg_sync = 1'b0; cfg_fast = 1'b0; rx_in = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 bit_tick after reset", int'(bit_tick), 0);
        check("R1 samp_tick after reset", int'(samp_tick), 0);
        check("R1 rx_vote after reset", int'(rx_vote), 1);
        check("R1 vote_valid after reset", int'(vote_valid), 0);
        expect_ticks("R1 first tick 64 clocks after reset", 64, 1);

        // R2: async slow
        wr(2, 1'b0, 1'b0);   expect_ticks("R2 slow X=2", 192, 2);
        wr(255, 1'b0, 1'b0); expect_ticks("R2 slow X=255", 16384, 1);
        // R3: async fast
        wr(5, 1'b0, 1'b1);   expect_ticks("R3 fast X=5", 96, 2);
        wr(255, 1'b0, 1'b1); expect_ticks("R3 fast X=255", 4096, 1);
        // R4: sync, fast flag ignored
        wr(3, 1'b1, 1'b1);   expect_ticks("R4 sync fast=1 X=3", 16, 3);
        wr(3, 1'b1, 1'b0);   expect_ticks("R4 sync fast=0 X=3", 16, 2);
        wr(0, 1'b1, 1'b0);   expect_ticks("R4 sync X=0", 4, 3);

        // R6: mid-period divisor rewrite
        wr(10, 1'b0, 1'b1);
        wait_n(50);
        wr(1, 1'b0, 1'b1);   expect_ticks("R6 rewrite restarts", 32, 2);
        // R7: mode-only change
        wr(3, 1'b0, 1'b0);
        wait_n(100);
        wr(3, 1'b0, 1'b1);   expect_ticks("R7 mode change restarts", 64, 1);

        // R8: three disabled clocks shift sync X=1 ticks from 8,16 to 11,19
        wr(1, 1'b1, 1'b0);
        tick_q.push_back(11); tick_q.push_back(19);
        wait_n(2); en = 1'b0;
        wait_n(5); en = 1'b1;
        wait_n(20);
        check("R8 stalled ticks", tick_q.size(), 0);
        tick_q.delete();

        // R9: strobe count per bit
        begin
            int cnt = 0;
            wr(1, 1'b0, 1'b1);
            tick_q.push_back(32);
            while (n <= 32) begin
                if (samp_tick) cnt++;
                @(negedge clk);
            end
            check("R9 strobes per async bit", cnt, 16);
            check("R9 async bit tick seen", tick_q.size(), 0);
            tick_q.delete();
        end
        begin
            int cnt = 0;
            watch_vote = 1'b1;
            wr(2, 1'b1, 1'b0);
            tick_q.push_back(12);
            while (n <= 12) begin
                if (samp_tick) cnt++;
                @(negedge clk);
            end
            check("R9 no strobes in sync", cnt, 0);
            check("R9 sync bit tick seen", tick_q.size(), 0);
            tick_q.delete();
        end

        // R10 / R11: majority patterns
        vote_case(1'b1, 1'b0, 1'b1);
        vote_case(1'b0, 1'b0, 1'b1);
        vote_case(1'b0, 1'b1, 1'b0);
        vote_case(1'b1, 1'b1, 1'b0);
        vote_case(1'b0, 1'b1, 1'b1);
        vote_case(1'b0, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule